// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a word-wide multiplier that sits on the register bus of a small 16-bit controller. Software picks the operation by where it writes the first operand. One location selects an unsigned product, one selects a two's-complement product, and one selects multiply-accumulate. Writing the second operand starts the operation. The unit finishes it in the same clock edge, so the 32-bit outcome can be read from two result words on the next bus access. No status flag has to be polled.

Both result words can also be written. Software uses this to preload the 32-bit accumulator, or to shift the high word into the low word, before it starts a chain of accumulate operations. The operands stay stored after an operation. A further write of the second operand alone runs the same operation again with the stored first operand and the stored mode.

Top module: `mac_top`

## Requirements
- R1: After reset every operand and result register reads zero and the stored mode is unsigned.
- R2: A write to offset 0x0 (unsigned), 0x2 (signed) or 0x4 (accumulate) stores the first operand and the mode. It leaves both result words unchanged.
- R3: A write to offset 0x8 stores the second operand and starts the operation. The new result is visible on the very next bus access.
- R4: In unsigned mode the result is the 32-bit unsigned product. The low half is read at offset 0xA and the high half at offset 0xC.
- R5: In signed mode both operands are two's complement and the result is the 32-bit signed product.
- R6: In accumulate mode the unsigned product is added to the current 32-bit result. Any carry beyond bit 31 is lost.
- R7: A write to offset 0xA replaces the low result word and a write to offset 0xC replaces the high result word. Neither write starts an operation.
- R8: A read of offset 0x0, 0x2 or 0x4 returns the stored first operand. A read of offset 0x8 returns the stored second operand.
- R9: A read of any other offset returns zero, and a write to any other offset changes no register.
- R10: A new write to offset 0x8 without a new first-operand write repeats the operation with the stored first operand and mode.
- R11: For the same operands, the low result word is identical in signed and unsigned mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read (when bus_en is high) |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word; zero when no read is under way |

## Verification
The bound checker watches every cycle. It checks the product or sum placed in the result after each trigger in all three modes, and it checks that first-operand writes and idle cycles leave the result untouched. It also checks that reads of unmapped offsets return zero. Some behaviours only show over a sequence of accesses, so the bench's scenarios have to show them. These are the reset contents, operand read-back, preload followed by an accumulate chain, repeated triggers with no new first operand, the wrap of the accumulator past 32 bits, and writes to unmapped offsets leaving every register intact.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // operating mode latched with the first operand
  typedef enum logic [1:0] {
    MODE_UNS = 2'd0,
    MODE_SGN = 2'd1,
    MODE_ACC = 2'd2
  } mac_mode_e;

  // byte offsets of the word registers (software depends on these)
  localparam int unsigned OFS_A_UNS  = 'h0;
  localparam int unsigned OFS_A_SGN  = 'h2;
  localparam int unsigned OFS_A_ACC  = 'h4;
  localparam int unsigned OFS_B      = 'h8;
  localparam int unsigned OFS_RES_LO = 'hA;
  localparam int unsigned OFS_RES_HI = 'hC;

  // one strobe per mapped register
  typedef struct packed {
    logic a_uns;
    logic a_sgn;
    logic a_acc;
    logic b;
    logic res_lo;
    logic res_hi;
  } mac_sel_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output mac_sel_t          wsel,
  output mac_sel_t          rsel
);
  mac_sel_t hit;

  always_comb begin
    hit.a_uns  = (bus_addr == ADDR_W'(OFS_A_UNS));
    hit.a_sgn  = (bus_addr == ADDR_W'(OFS_A_SGN));
    hit.a_acc  = (bus_addr == ADDR_W'(OFS_A_ACC));
    hit.b      = (bus_addr == ADDR_W'(OFS_B));
    hit.res_lo = (bus_addr == ADDR_W'(OFS_RES_LO));
    hit.res_hi = (bus_addr == ADDR_W'(OFS_RES_HI));
  end

  assign wsel = (bus_en &&  bus_we) ? hit : '0;
  assign rsel = (bus_en && !bus_we) ? hit : '0;
endmodule

// File: rtl/mac_mul_core.sv
module mac_mul_core
  import mac_pkg::*;
#(
  parameter int DW = 16,
  localparam int RW = 2 * DW
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  mac_mode_e     mode,
  input  logic [RW-1:0] acc_in,
  output logic [RW-1:0] result
);
  logic          ext_a, ext_b;
  logic [RW-1:0] wide_a, wide_b, prod;

  // sign bits only take part in signed mode
  assign ext_a  = (mode == MODE_SGN) & op_a[DW-1];
  assign ext_b  = (mode == MODE_SGN) & op_b[DW-1];
  assign wide_a = {{DW{ext_a}}, op_a};
  assign wide_b = {{DW{ext_b}}, op_b};
  // product modulo 2^RW equals the signed product for extended inputs
  assign prod   = wide_a * wide_b;

  always_comb begin
    if (mode == MODE_ACC) result = acc_in + prod;
    else                  result = prod;
  end
endmodule

// File: rtl/mac_rdmux.sv
module mac_rdmux
  import mac_pkg::*;
#(
  parameter int DW = 16,
  localparam int RW = 2 * DW
) (
  input  mac_sel_t      rsel,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [RW-1:0] res,
  output logic [DW-1:0] rdata
);
  logic a_hit;
  assign a_hit = rsel.a_uns | rsel.a_sgn | rsel.a_acc;

  // and-or mux: unselected and unmapped reads collapse to zero
  assign rdata = ({DW{a_hit}}       & op_a)
               | ({DW{rsel.b}}      & op_b)
               | ({DW{rsel.res_lo}} & res[DW-1:0])
               | ({DW{rsel.res_hi}} & res[RW-1:DW]);
endmodule

// File: rtl/mac_top.sv
module mac_top
  import mac_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata
);
  localparam int RW = 2 * DW;

  mac_sel_t      wsel, rsel;
  logic [DW-1:0] op_a_q, op_b_q;
  logic [RW-1:0] res_q, core_res;
  mac_mode_e     mode_q;

  mac_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wsel     (wsel),
    .rsel     (rsel)
  );

  // the trigger data goes straight into the core, so the result lands at the write edge
  mac_mul_core #(.DW(DW)) u_core (
    .op_a   (op_a_q),
    .op_b   (bus_wdata),
    .mode   (mode_q),
    .acc_in (res_q),
    .result (core_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a_q <= '0;
      op_b_q <= '0;
      mode_q <= MODE_UNS;
    end else begin
      if (wsel.a_uns) begin op_a_q <= bus_wdata; mode_q <= MODE_UNS; end
      if (wsel.a_sgn) begin op_a_q <= bus_wdata; mode_q <= MODE_SGN; end
      if (wsel.a_acc) begin op_a_q <= bus_wdata; mode_q <= MODE_ACC; end
      if (wsel.b)     op_b_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (wsel.b) begin
      res_q <= core_res;
    end else begin
      if (wsel.res_lo) res_q[DW-1:0]  <= bus_wdata;
      if (wsel.res_hi) res_q[RW-1:DW] <= bus_wdata;
    end
  end

  mac_rdmux #(.DW(DW)) u_rd (
    .rsel  (rsel),
    .op_a  (op_a_q),
    .op_b  (op_b_q),
    .res   (res_q),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/mac_chk.sv
module mac_chk
  import mac_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 4,
  localparam int RW    = 2 * DW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [DW-1:0]     op_a_q,
  input logic [RW-1:0]     res_q,
  input mac_mode_e         mode_q
);
  logic          wr, rd, trig, a_wr, mapped;
  logic [RW-1:0] u_prod, s_prod;

  assign wr     = bus_en && bus_we;
  assign rd     = bus_en && !bus_we;
  assign trig   = wr && (bus_addr == ADDR_W'(OFS_B));
  assign a_wr   = wr && (bus_addr == ADDR_W'(OFS_A_UNS) || bus_addr == ADDR_W'(OFS_A_SGN)
                      || bus_addr == ADDR_W'(OFS_A_ACC));
  assign mapped = bus_addr == ADDR_W'(OFS_A_UNS) || bus_addr == ADDR_W'(OFS_A_SGN)
               || bus_addr == ADDR_W'(OFS_A_ACC) || bus_addr == ADDR_W'(OFS_B)
               || bus_addr == ADDR_W'(OFS_RES_LO) || bus_addr == ADDR_W'(OFS_RES_HI);
  assign u_prod = {{DW{1'b0}}, op_a_q} * {{DW{1'b0}}, bus_wdata};
  assign s_prod = {{DW{op_a_q[DW-1]}}, op_a_q} * {{DW{bus_wdata[DW-1]}}, bus_wdata};

  // R2: first-operand write never disturbs the result
  a_r2_opa_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |=> $stable(res_q));

  // R4: unsigned trigger
  a_r4_unsigned_product: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_q == MODE_UNS) |=> res_q == $past(u_prod));

  // R5: signed trigger
  a_r5_signed_product: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_q == MODE_SGN) |=> res_q == $past(s_prod));

  // R6: accumulate trigger
  a_r6_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_q == MODE_ACC) |=> res_q == $past(res_q) + $past(u_prod));

  // R9: unmapped reads return zero
  a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mapped) |-> bus_rdata == '0);

  // R9: cycles without a mapped write change neither operand A nor the result
  a_r9_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && mapped) |=> ($stable(res_q) && $stable(op_a_q)));
endmodule

bind mac_top mac_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .op_a_q    (op_a_q),
  .res_q     (res_q),
  .mode_q    (mode_q)
);

// File: tb/sim_mac_top.sv
`timescale 1ns/1ps
module sim_mac_top;
  localparam logic [3:0] A_UNS = 4'h0, A_SGN = 4'h2, A_ACC = 4'h4, B_OP = 4'h8,
                         R_LO = 4'hA, R_HI = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of the register contents
  logic [15:0] m_a, m_b;
  logic [31:0] m_res;
  int          m_mode;   // 0 unsigned, 1 signed, 2 accumulate

  always #4 clk = ~clk;   // 125 MHz

  mac_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] ref_op(int mode, logic [15:0] a, logic [15:0] b,
                                         logic [31:0] acc);
    logic [31:0] ua, ub, sa, sb;
    ua = {16'h0, a};
    ub = {16'h0, b};
    sa = {{16{a[15]}}, a};
    sb = {{16{b[15]}}, b};
    if (mode == 1) return sa * sb;
    if (mode == 2) return acc + ua * ub;
    return ua * ub;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // writes stay driven until the next access task takes the bus
  task automatic wr(logic [3:0] addr, logic [15:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
  endtask

  task automatic rd(logic [3:0] addr, output logic [15:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = addr; bus_wdata = '0;
    #2 data = bus_rdata;
  endtask

  task automatic set_a(int mode, logic [15:0] a);
    wr(mode == 0 ? A_UNS : (mode == 1 ? A_SGN : A_ACC), a);
    m_a = a; m_mode = mode;
  endtask

  task automatic trig_and_check(string req, logic [15:0] b);
    logic [15:0] lo, hi;
    wr(B_OP, b);
    m_res = ref_op(m_mode, m_a, b, m_res);
    m_b = b;
    rd(R_LO, lo);   // very next access after the trigger
    rd(R_HI, hi);
    check(req, {hi, lo}, m_res);
  endtask

  task automatic preload(logic [31:0] v);
    wr(R_LO, v[15:0]);
    wr(R_HI, v[31:16]);
    m_res = v;
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, lo_u, lo_s;
    void'($urandom(32'h5eed_1234));
    m_a = '0; m_b = '0; m_res = '0; m_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    rd(A_UNS, v); check("R1 op a", {16'h0, v}, 32'h0);
    rd(B_OP,  v); check("R1 op b", {16'h0, v}, 32'h0);
    rd(R_LO,  v); check("R1 res lo", {16'h0, v}, 32'h0);
    rd(R_HI,  v); check("R1 res hi", {16'h0, v}, 32'h0);
    // R1: default mode is unsigned -> trigger without operand A write
    m_a = 16'h0; trig_and_check("R1 default mode", 16'h1234);

    // R2 / R8: operand write stores value, leaves result, reads back
    preload(32'hCAFE_0123);
    set_a(1, 16'hBEEF);
    rd(R_LO, v); check("R2 res lo kept", {16'h0, v}, 32'h0123);
    rd(R_HI, v); check("R2 res hi kept", {16'h0, v}, 32'hCAFE);
    rd(A_UNS, v); check("R8 read at 0x0", {16'h0, v}, 32'hBEEF);
    rd(A_ACC, v); check("R8 read at 0x4", {16'h0, v}, 32'hBEEF);

    // R4 / R5 / R3 corner products
    set_a(0, 16'hFFFF); trig_and_check("R4 ffff*ffff", 16'hFFFF);
    set_a(1, 16'hFFFF); trig_and_check("R5 -1*-1", 16'hFFFF);
    set_a(1, 16'h8000); trig_and_check("R5 min*min", 16'h8000);
    set_a(1, 16'h7FFF); trig_and_check("R5 max*min", 16'h8000);
    rd(B_OP, v); check("R8 read op b", {16'h0, v}, 32'h8000);

    // R11: low word matches between modes
    set_a(0, 16'hA5C3); wr(B_OP, 16'h9E17); rd(R_LO, lo_u);
    set_a(1, 16'hA5C3); wr(B_OP, 16'h9E17); rd(R_LO, lo_s);
    check("R11 low word", {16'h0, lo_s}, {16'h0, lo_u});
    m_b = 16'h9E17; m_res = ref_op(1, 16'hA5C3, 16'h9E17, 32'h0);

    // R6 / R7: preload then wrap past 32 bits
    preload(32'hFFFF_FFFF);
    set_a(2, 16'h0001); trig_and_check("R6 wrap", 16'h0001);
    preload(32'h0001_0000);
    set_a(2, 16'hFFFF); trig_and_check("R6 acc big", 16'hFFFF);
    // R10: repeat trigger accumulates again with stored operand
    trig_and_check("R10 repeat acc", 16'h0003);
    set_a(0, 16'h0100); trig_and_check("R3 uns", 16'h0010);
    trig_and_check("R10 repeat uns", 16'h0020);

    // R9: unmapped offsets
    wr(4'h6, 16'h1111); wr(4'hE, 16'h2222); wr(4'h1, 16'h3333);
    rd(4'h6, v); check("R9 read 0x6", {16'h0, v}, 32'h0);
    rd(4'hE, v); check("R9 read 0xE", {16'h0, v}, 32'h0);
    rd(A_SGN, v); check("R9 op a intact", {16'h0, v}, {16'h0, m_a});
    rd(B_OP, v);  check("R9 op b intact", {16'h0, v}, {16'h0, m_b});
    rd(R_LO, v);  check("R9 res lo intact", {16'h0, v}, {16'h0, m_res[15:0]});
    rd(R_HI, v);  check("R9 res hi intact", {16'h0, v}, {16'h0, m_res[31:16]});

    // random mix of modes, preloads and repeats (R4 R5 R6 R10)
    for (int i = 0; i < 300; i++) begin
      int mode;
      mode = $urandom_range(0, 2);
      if ($urandom_range(0, 7) == 0) preload($urandom);
      if ($urandom_range(0, 4) != 0) set_a(mode, 16'($urandom));
      case (m_mode)
        0: trig_and_check("R4 random", 16'($urandom));
        1: trig_and_check("R5 random", 16'($urandom));
        default: trig_and_check("R6 random", 16'($urandom));
      endcase
    end

    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule